// File: doc/BRIEF.md
# Receive Buffer Ring Fetcher

This block reads the next receive buffer descriptor out of a circular area in system memory each time it is commanded to. The ring is described by a 16-bit upper address, which is common to all of its entries, and by four 16-bit pointers: a ring start, a ring end, a read pointer owned by this block, and a write pointer owned by software. When a fetch is accepted, the block issues a single memory read burst at the ring entry under the read pointer. It captures four 16-bit words from that burst: the low and high halves of the current buffer address, then the low and high halves of the buffer word count.

When the last word has arrived, the block moves the read pointer forward by one entry. The entry size depends on the data-width mode. If the new pointer lands on the ring end, the block wraps it back to the ring start. If the pointer then meets the software write pointer, no more buffers are left, and the block pulses a status-set bit for the interrupt logic. A busy flag plays the role of the pending command bit. It clears in the same cycle that the done pulse appears.

Top module: `rx_ring_fetch`

## Requirements
- R1: The cycle after a fetch is accepted, `mem_rd_req` is high for exactly one cycle. `mem_rd_addr` is then `{upper_addr, rd_ptr}`, and `mem_rd_bytes` is 8 in 16-bit mode and 16 in 32-bit mode.
- R2: The design captures a word from `mem_rd_data` only in a cycle where `mem_rd_valid` is high. The four captured words go, in arrival order, to `buf_addr_lo`, `buf_addr_hi`, `word_cnt_lo` and `word_cnt_hi`.
- R3: When a fetch completes, `rd_ptr` advances modulo 2^16 by 8 (when `wide_mode` is 0) or by 16 (when `wide_mode` is 1). The mode used is the one sampled when the request was accepted.
- R4: If the advanced pointer equals `ring_end`, `rd_ptr` is loaded with `ring_start` instead.
- R5: If the final `rd_ptr` equals `wr_ptr`, `stat_set` is 16'h0020 (bit 5) in the cycle that `done` is high. In every other cycle `stat_set` is zero.
- R6: `busy` rises in the cycle after an accepted `fetch_req`. It stays high until the fetch ends. `done` is a one-cycle pulse that appears in the first cycle with `busy` low, one cycle after the last data word.
- R7: A `fetch_req` that arrives while `busy` is high is ignored. No second read burst is issued before `done`.
- R8: After reset, `busy`, `done`, `stat_set`, `mem_rd_req`, `rd_ptr` and the four loaded word registers are all zero.
- R9: `rd_ptr_load` writes `rd_ptr_wdata` into `rd_ptr` when the block is idle. While `busy` is high the load is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_req | input | 1 | Fetch command |
| wide_mode | input | 1 | 1 selects 32-bit data width, 0 selects 16-bit |
| upper_addr | input | 16 | Upper 16 address bits of the ring |
| rd_ptr_load | input | 1 | Load strobe for the read pointer |
| rd_ptr_wdata | input | 16 | Value for the read pointer load |
| ring_start | input | 16 | Ring start pointer |
| ring_end | input | 16 | Ring end pointer |
| wr_ptr | input | 16 | Software write pointer |
| mem_rd_req | output | 1 | Burst request pulse |
| mem_rd_addr | output | 32 | Burst byte address |
| mem_rd_bytes | output | 5 | Burst length in bytes |
| mem_rd_valid | input | 1 | Data word valid strobe |
| mem_rd_data | input | 16 | Data word (low half of each location in 32-bit mode) |
| busy | output | 1 | Fetch in progress (command pending) |
| done | output | 1 | Fetch complete pulse |
| stat_set | output | 16 | Status-set pulse vector, bit 5 means buffers exhausted |
| buf_addr_lo | output | 16 | Buffer address, low half |
| buf_addr_hi | output | 16 | Buffer address, high half |
| word_cnt_lo | output | 16 | Buffer word count, low half |
| word_cnt_hi | output | 16 | Buffer word count, high half |
| rd_ptr | output | 16 | Ring read pointer |

## Verification
The bench goes after the cases where the advance step lands exactly on the ring end, and the case where a wrap lands exactly on the write pointer. A design that compares before the wrap would flag exhaustion one entry late, or would wrap one entry early.

Data strobes arrive with random gaps, and garbage data sits on the bus during those gaps. A capture that ignores the strobe would load the wrong words.

In the middle of a burst the bench sends a second request and a pointer load. A design that accepted either would issue an extra burst or advance from the wrong base.

In half of the fetches it switches between 16-bit and 32-bit step sizes. A design that ignored the mode would show a wrong step size.

// File: rtl/rrf_pkg.sv
package rrf_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BURST  = 2'd1,
    ST_FINISH = 2'd2
  } rrf_state_e;

  // Bytes covered by one ring entry: words times word size, doubled in wide mode.
  function automatic int unsigned rrf_entry_bytes(input int unsigned words,
                                                  input int unsigned word_bytes,
                                                  input logic        wide);
    return words * word_bytes * (wide ? 2 : 1);
  endfunction

endpackage

// File: rtl/rrf_ctrl.sv
module rrf_ctrl
  import rrf_pkg::*;
#(
  parameter int NUM_WORDS = 4,
  parameter int BEAT_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_req,
  input  logic              mem_rd_valid,
  output logic              accept,
  output logic              issue_q,
  output logic              busy,
  output logic              capture_en,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              last_beat,
  output logic              finish
);

  localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(NUM_WORDS - 1);

  rrf_state_e state_q;

  assign busy       = (state_q != ST_IDLE);
  assign accept     = (state_q == ST_IDLE) && fetch_req;
  assign capture_en = (state_q == ST_BURST) && mem_rd_valid;
  assign last_beat  = capture_en && (beat_idx == LAST_IDX);
  assign finish     = (state_q == ST_FINISH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      beat_idx <= '0;
      issue_q  <= 1'b0;
    end else begin
      issue_q <= accept;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q  <= ST_BURST;
            beat_idx <= '0;
          end
        end
        ST_BURST: begin
          if (capture_en) begin
            if (beat_idx == LAST_IDX) begin
              state_q  <= ST_FINISH;
              beat_idx <= '0;
            end else begin
              beat_idx <= beat_idx + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rrf_capture.sv
module rrf_capture #(
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 16,
  parameter int BEAT_W    = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        capture_en,
  input  logic [BEAT_W-1:0]           beat_idx,
  input  logic [WORD_W-1:0]           mem_rd_data,
  output logic [NUM_WORDS*WORD_W-1:0] words_flat
);

  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
    logic [WORD_W-1:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        word_q <= '0;
      end else if (capture_en && (beat_idx == BEAT_W'(gi))) begin
        word_q <= mem_rd_data;
      end
    end
    assign words_flat[gi*WORD_W +: WORD_W] = word_q;
  end

endmodule

// File: rtl/rrf_ptr.sv
module rrf_ptr
  import rrf_pkg::*;
#(
  parameter int PTR_W     = 16,
  parameter int UPPER_W   = 16,
  parameter int NUM_WORDS = 4,
  parameter int WORD_W    = 16,
  parameter int BYTES_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     accept,
  input  logic                     idle,
  input  logic                     finish,
  input  logic                     wide_mode,
  input  logic [UPPER_W-1:0]       upper_addr,
  input  logic                     rd_ptr_load,
  input  logic [PTR_W-1:0]         rd_ptr_wdata,
  input  logic [PTR_W-1:0]         ring_start,
  input  logic [PTR_W-1:0]         ring_end,
  input  logic [PTR_W-1:0]         wr_ptr,
  output logic [PTR_W-1:0]         rd_ptr,
  output logic [UPPER_W+PTR_W-1:0] mem_rd_addr,
  output logic [BYTES_W-1:0]       mem_rd_bytes,
  output logic                     done,
  output logic                     exhaust_q,
  output logic                     wrap_hit,
  output logic                     exhaust_hit
);

  localparam int WORD_BYTES = WORD_W / 8;
  localparam logic [PTR_W-1:0] STEP_NARROW = PTR_W'(rrf_entry_bytes(NUM_WORDS, WORD_BYTES, 1'b0));
  localparam logic [PTR_W-1:0] STEP_WIDE   = PTR_W'(rrf_entry_bytes(NUM_WORDS, WORD_BYTES, 1'b1));

  // Pointer plus one entry, before any wrap.
  function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] cur,
                                                input logic             wide);
    return cur + (wide ? STEP_WIDE : STEP_NARROW);
  endfunction

  logic             wide_q;
  logic [PTR_W-1:0] stepped;
  logic [PTR_W-1:0] next_ptr;

  assign stepped     = step_ptr(rd_ptr, wide_q);
  assign wrap_hit    = (stepped == ring_end);
  assign next_ptr    = wrap_hit ? ring_start : stepped;
  assign exhaust_hit = finish && (next_ptr == wr_ptr);
  assign mem_rd_bytes = BYTES_W'(wide_q ? STEP_WIDE : STEP_NARROW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr      <= '0;
      wide_q      <= 1'b0;
      mem_rd_addr <= '0;
      done        <= 1'b0;
      exhaust_q   <= 1'b0;
    end else begin
      done      <= finish;
      exhaust_q <= exhaust_hit;
      if (accept) begin
        wide_q      <= wide_mode;
        mem_rd_addr <= {upper_addr, rd_ptr};
      end
      if (finish) begin
        rd_ptr <= next_ptr;
      end else if (idle && !accept && rd_ptr_load) begin
        rd_ptr <= rd_ptr_wdata;
      end
    end
  end

endmodule

// File: rtl/rx_ring_fetch.sv
module rx_ring_fetch #(
  parameter int PTR_W   = 16,
  parameter int UPPER_W = 16,
  parameter int WORD_W  = 16,
  parameter int STAT_W  = 16,
  parameter int EXH_BIT = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     fetch_req,
  input  logic                     wide_mode,
  input  logic [UPPER_W-1:0]       upper_addr,
  input  logic                     rd_ptr_load,
  input  logic [PTR_W-1:0]         rd_ptr_wdata,
  input  logic [PTR_W-1:0]         ring_start,
  input  logic [PTR_W-1:0]         ring_end,
  input  logic [PTR_W-1:0]         wr_ptr,
  output logic                     mem_rd_req,
  output logic [UPPER_W+PTR_W-1:0] mem_rd_addr,
  output logic [4:0]               mem_rd_bytes,
  input  logic                     mem_rd_valid,
  input  logic [WORD_W-1:0]        mem_rd_data,
  output logic                     busy,
  output logic                     done,
  output logic [STAT_W-1:0]        stat_set,
  output logic [WORD_W-1:0]        buf_addr_lo,
  output logic [WORD_W-1:0]        buf_addr_hi,
  output logic [WORD_W-1:0]        word_cnt_lo,
  output logic [WORD_W-1:0]        word_cnt_hi,
  output logic [PTR_W-1:0]         rd_ptr
);

  localparam int NUM_WORDS = 4;
  localparam int BEAT_W    = $clog2(NUM_WORDS);
  localparam int BYTES_W   = 5;

  // Internal events, named for the checker.
  logic                        accept;
  logic                        capture_en;
  logic [BEAT_W-1:0]           beat_idx;
  logic                        last_beat;
  logic                        finish;
  logic                        exhaust_q;
  logic                        wrap_hit;
  logic                        exhaust_hit;
  logic [NUM_WORDS*WORD_W-1:0] words_flat;

  rrf_ctrl #(.NUM_WORDS(NUM_WORDS), .BEAT_W(BEAT_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .fetch_req    (fetch_req),
    .mem_rd_valid (mem_rd_valid),
    .accept       (accept),
    .issue_q      (mem_rd_req),
    .busy         (busy),
    .capture_en   (capture_en),
    .beat_idx     (beat_idx),
    .last_beat    (last_beat),
    .finish       (finish)
  );

  rrf_capture #(.NUM_WORDS(NUM_WORDS), .WORD_W(WORD_W), .BEAT_W(BEAT_W)) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .capture_en  (capture_en),
    .beat_idx    (beat_idx),
    .mem_rd_data (mem_rd_data),
    .words_flat  (words_flat)
  );

  rrf_ptr #(
    .PTR_W(PTR_W), .UPPER_W(UPPER_W), .NUM_WORDS(NUM_WORDS),
    .WORD_W(WORD_W), .BYTES_W(BYTES_W)
  ) u_ptr (
    .clk          (clk),
    .rst_n        (rst_n),
    .accept       (accept),
    .idle         (!busy),
    .finish       (finish),
    .wide_mode    (wide_mode),
    .upper_addr   (upper_addr),
    .rd_ptr_load  (rd_ptr_load),
    .rd_ptr_wdata (rd_ptr_wdata),
    .ring_start   (ring_start),
    .ring_end     (ring_end),
    .wr_ptr       (wr_ptr),
    .rd_ptr       (rd_ptr),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_bytes (mem_rd_bytes),
    .done         (done),
    .exhaust_q    (exhaust_q),
    .wrap_hit     (wrap_hit),
    .exhaust_hit  (exhaust_hit)
  );

  assign buf_addr_lo = words_flat[0*WORD_W +: WORD_W];
  assign buf_addr_hi = words_flat[1*WORD_W +: WORD_W];
  assign word_cnt_lo = words_flat[2*WORD_W +: WORD_W];
  assign word_cnt_hi = words_flat[3*WORD_W +: WORD_W];
  assign stat_set    = STAT_W'(exhaust_q) << EXH_BIT;

endmodule

// File: rtl/rx_ring_fetch_chk.sv
module rx_ring_fetch_chk #(
  parameter int PTR_W   = 16,
  parameter int UPPER_W = 16,
  parameter int STAT_W  = 16,
  parameter int EXH_BIT = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     busy,
  input logic                     done,
  input logic [STAT_W-1:0]        stat_set,
  input logic                     mem_rd_req,
  input logic [UPPER_W+PTR_W-1:0] mem_rd_addr,
  input logic [PTR_W-1:0]         rd_ptr,
  input logic [UPPER_W-1:0]       upper_addr,
  input logic [PTR_W-1:0]         ring_start,
  input logic [PTR_W-1:0]         ring_end,
  input logic                     last_beat
);

  a_r1_burst_addr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (mem_rd_addr == {upper_addr, rd_ptr}));

  a_r3_ptr_held_in_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rd_ptr));

  a_r4_never_parks_on_end: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (ring_start != ring_end)) |-> (rd_ptr != ring_end));

  a_r5_exhaust_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_set != '0) |-> (done && (stat_set[EXH_BIT] == 1'b1) && $onehot0(stat_set)));

  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> ##1 done);

  a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r7_one_burst: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> $rose(busy));

endmodule

bind rx_ring_fetch rx_ring_fetch_chk #(
  .PTR_W(PTR_W), .UPPER_W(UPPER_W), .STAT_W(STAT_W), .EXH_BIT(EXH_BIT)
) u_chk (.*);

// File: tb/rx_ring_fetch_test.sv
module rx_ring_fetch_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_req, wide_mode, rd_ptr_load, mem_rd_valid;
  logic [15:0] upper_addr, rd_ptr_wdata, ring_start, ring_end, wr_ptr, mem_rd_data;
  logic        mem_rd_req, busy, done;
  logic [31:0] mem_rd_addr;
  logic [4:0]  mem_rd_bytes;
  logic [15:0] stat_set, buf_addr_lo, buf_addr_hi, word_cnt_lo, word_cnt_hi, rd_ptr;

  int compared = 0;
  int mismatched = 0;
  int req_seen = 0;
  int fetches = 0;
  logic [15:0] exp_ptr = 16'h0;

  always #10 clk = ~clk;

  rx_ring_fetch uut (.*);

  always @(posedge clk) if (rst_n && mem_rd_req) req_seen++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ring_next(input logic [15:0] p, input logic wide,
                                            input logic [15:0] s, input logic [15:0] e);
    logic [15:0] n;
    n = p + (wide ? 16'd16 : 16'd8);
    return (n == e) ? s : n;
  endfunction

  task automatic load_ptr(input logic [15:0] v);
    @(negedge clk);
    rd_ptr_load = 1'b1; rd_ptr_wdata = v;
    @(negedge clk);
    rd_ptr_load = 1'b0;
    chk("R9 load", rd_ptr, v);
    exp_ptr = v;
  endtask

  task automatic fetch(input logic wide, input bit poke);
    logic [15:0] w [4];
    logic [15:0] nxt;
    for (int k = 0; k < 4; k++) w[k] = 16'($urandom);
    @(negedge clk);
    wide_mode = wide; fetch_req = 1'b1;
    @(negedge clk);
    fetch_req = 1'b0;
    wide_mode = ~wide;
    fetches++;
    chk("R6 busy rise", busy, 1'b1);
    chk("R1 req", mem_rd_req, 1'b1);
    chk("R1 addr", mem_rd_addr, {upper_addr, exp_ptr});
    chk("R1 bytes", mem_rd_bytes, wide ? 5'd16 : 5'd8);
    for (int k = 0; k < 4; k++) begin
      int gap;
      gap = int'($urandom % 3);
      for (int g = 0; g < gap; g++) begin
        mem_rd_valid = 1'b0; mem_rd_data = 16'($urandom);
        @(negedge clk);
      end
      if (poke && k == 1) begin
        fetch_req = 1'b1; rd_ptr_load = 1'b1; rd_ptr_wdata = ~exp_ptr;
      end
      mem_rd_valid = 1'b1; mem_rd_data = w[k];
      @(negedge clk);
      fetch_req = 1'b0; rd_ptr_load = 1'b0;
      if (k == 0) chk("R1 single pulse", mem_rd_req, 1'b0);
    end
    mem_rd_valid = 1'b0; mem_rd_data = 16'($urandom);
    chk("R6 busy hold", busy, 1'b1);
    chk("R6 no early done", done, 1'b0);
    @(negedge clk);
    nxt = ring_next(exp_ptr, wide, ring_start, ring_end);
    chk("R6 done", done, 1'b1);
    chk("R6 busy drop", busy, 1'b0);
    chk("R3 R4 R9 ptr", rd_ptr, nxt);
    chk("R5 status", stat_set, (nxt == wr_ptr) ? 16'h0020 : 16'h0000);
    chk("R2 buf lo", buf_addr_lo, w[0]);
    chk("R2 buf hi", buf_addr_hi, w[1]);
    chk("R2 cnt lo", word_cnt_lo, w[2]);
    chk("R2 cnt hi", word_cnt_hi, w[3]);
    exp_ptr = nxt;
    @(negedge clk);
    chk("R6 done pulse", done, 1'b0);
    chk("R5 pulse", stat_set, 16'h0);
    chk("R7 bursts", req_seen, fetches);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; fetch_req = 0; wide_mode = 0; rd_ptr_load = 0; mem_rd_valid = 0;
    upper_addr = 16'h1234; rd_ptr_wdata = 0; ring_start = 16'h0100;
    ring_end = 16'h0140; wr_ptr = 16'h0138; mem_rd_data = 0;
    repeat (3) @(negedge clk);
    chk("R8 busy", busy, 0);
    chk("R8 done", done, 0);
    chk("R8 stat", stat_set, 0);
    chk("R8 req", mem_rd_req, 0);
    chk("R8 ptr", rd_ptr, 0);
    chk("R8 words", {buf_addr_lo, buf_addr_hi, word_cnt_lo, word_cnt_hi}, 0);
    rst_n = 1'b1;

    load_ptr(16'h0100);
    fetch(1'b0, 0);                 // R3 narrow step
    fetch(1'b1, 0);                 // R3 wide step
    load_ptr(16'h0130);
    fetch(1'b0, 0);                 // R5 lands on write pointer
    @(negedge clk); wr_ptr = 16'h0200;
    load_ptr(16'h0138);
    fetch(1'b0, 0);                 // R4 wrap, no exhaustion
    @(negedge clk); wr_ptr = 16'h0100;
    load_ptr(16'h0130);
    fetch(1'b1, 0);                 // R4 R5 wrap onto write pointer
    fetch(1'b0, 1);                 // R7 R9 request and load during burst
    load_ptr(16'hFFF8);
    @(negedge clk); ring_end = 16'h0140;
    fetch(1'b0, 0);                 // R3 modulo 2^16

    for (int it = 0; it < 40; it++) begin
      logic wide;
      logic [15:0] p;
      wide = 1'($urandom);
      p = 16'($urandom);
      @(negedge clk);
      upper_addr = 16'($urandom);
      ring_start = 16'($urandom);
      ring_end   = ($urandom % 2) ? p + (wide ? 16'd16 : 16'd8) : 16'($urandom);
      wr_ptr     = ($urandom % 2) ? ring_next(p, wide, ring_start, ring_end) : 16'($urandom);
      load_ptr(p);
      fetch(wide, ($urandom % 4) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: run did not finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule